// File: doc/BRIEF.md
# Aligned Quadword Load/Store Sequencer

This block carries out 128-bit loads and stores over a memory port that is only 64 bits wide. A command carries a 64-bit base value, a signed 16-bit displacement, a register index and, for stores, 128 bits of data. The block sign-extends the displacement, adds it to the base and clears the bottom four bits of the sum. A misaligned address is therefore rounded down to a 16-byte boundary rather than faulting. The quadword then moves as two doubleword beats. The lower half goes first, at the rounded address, and the upper half follows at that address plus 8.

Commands enter through a valid/ready stream. `cmd_ready` is high only while the sequencer is idle, and a command is taken on any cycle in which `cmd_valid` and `cmd_ready` are both high. Back-pressure from memory works as follows. A beat request stays up, with its address, write-enable and write data held steady, until `mem_ready` is seen high. A load beat then waits for `mem_rvalid`, which memory raises at least one cycle after it accepts the request. When a load finishes, the two returned doublewords are joined into one 128-bit write-back, presented for a single cycle together with the register index. A load aimed at register 0 is dropped without touching memory. A store from register 0 is carried out normally.

Top module: `qls_seq`

## Requirements
- R1: The beat address base is (cmd_base + sign-extended cmd_offset) with bits [3:0] forced to zero. Every beat address therefore has bits [2:0] zero.
- R2: An executed command makes exactly two memory accesses: the first at the aligned address and the second at the aligned address plus 8.
- R3: The lower beat is always issued before the upper beat. For stores, the first beat writes cmd_wdata[63:0] and the second writes cmd_wdata[127:64].
- R4: For a load, wb_data = {rdata of second beat, rdata of first beat} and wb_reg = cmd_reg. wb_valid is high for exactly one cycle, the cycle after the one in which the second beat's mem_rvalid is sampled.
- R5: A load with cmd_reg = 0 issues no memory request and produces no write-back, and cmd_ready is high again on the next cycle.
- R6: A store with cmd_reg = 0 is performed like any other store.
- R7: cmd_ready is high only while idle. It goes low in the cycle after an executed command is accepted and stays low until that command completes.
- R8: While mem_req is high and mem_ready is low, mem_req, mem_addr, mem_we and mem_wdata hold their values into the next cycle. No new request is raised while a load beat awaits mem_rvalid.
- R9: A store never raises wb_valid.
- R10: After reset, cmd_ready = 1, mem_req = 0 and wb_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_base | input | 64 | Base address value |
| cmd_offset | input | 16 | Signed displacement |
| cmd_reg | input | 5 | Target (load) or source (store) register index |
| cmd_wdata | input | 128 | Store data; bits [63:0] are the lower half |
| mem_req | output | 1 | Beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 64 | Beat byte address |
| mem_wdata | output | 64 | Beat write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| wb_valid | output | 1 | Load result valid (one cycle) |
| wb_reg | output | 5 | Load target register index |
| wb_data | output | 128 | Assembled load result |

## Verification
Directed commands use an unaligned base with a small positive displacement and a base with a negative displacement. These show whether the sign extension and the clearing of the low four bits are both correct, because each error lands the beats on a different doubleword. Random loads and stores are interleaved against the same memory model. A later load then reads back earlier stores, which exposes swapped halves or a wrong second-beat address. The memory model withholds mem_ready at random and delays mem_rvalid by a random amount. This separates a design that respects back-pressure and response timing from one that only works with an ideal memory. Loads and stores with register index 0 show the asymmetry between skipping a load and still performing a store.

// File: rtl/qls_pkg.sv
package qls_pkg;
  typedef enum logic [1:0] {
    QS_IDLE = 2'd0,
    QS_LO   = 2'd1,
    QS_HI   = 2'd2,
    QS_DONE = 2'd3
  } qls_state_e;
endpackage

// File: rtl/qls_addr_gen.sv
module qls_addr_gen #(
  parameter int AW      = 64,
  parameter int OFS_W   = 16,
  parameter int ALIGN_B = 4
) (
  input  logic [AW-1:0]    base,
  input  logic [OFS_W-1:0] ofs,
  output logic [AW-1:0]    aligned
);
  logic [AW-1:0] ofs_ext;
  logic [AW-1:0] sum;

  always_comb begin
    ofs_ext = {{(AW-OFS_W){ofs[OFS_W-1]}}, ofs};
    sum     = base + ofs_ext;
    aligned = {sum[AW-1:ALIGN_B], {ALIGN_B{1'b0}}};
  end
endmodule

// File: rtl/qls_ctrl.sv
module qls_ctrl
  import qls_pkg::*;
#(
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_store,
  input  logic [RIDX_W-1:0] cmd_reg,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  output logic              cmd_ready,
  output logic              go,
  output logic              mem_req,
  output logic              is_store,
  output logic              beat_hi,
  output logic              cap_lo,
  output logic              cap_hi,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_reg
);
  qls_state_e st_q, st_d;
  logic issued_q, issued_d;
  logic store_q;
  logic [RIDX_W-1:0] reg_q;
  logic accept, skip, beat_act, acc, beat_end;

  always_comb begin
    cmd_ready = (st_q == QS_IDLE);
    accept    = cmd_valid && cmd_ready;
    skip      = accept && !cmd_store && (cmd_reg == '0);
    go        = accept && !skip;
    beat_act  = (st_q == QS_LO) || (st_q == QS_HI);
    mem_req   = beat_act && !issued_q;
    acc       = mem_req && mem_ready;
    beat_end  = store_q ? acc : (issued_q && mem_rvalid);
    beat_hi   = (st_q == QS_HI);
    cap_lo    = (st_q == QS_LO) && !store_q && issued_q && mem_rvalid;
    cap_hi    = (st_q == QS_HI) && !store_q && issued_q && mem_rvalid;
    wb_valid  = (st_q == QS_DONE) && !store_q;
    wb_reg    = reg_q;
    is_store  = store_q;

    st_d = st_q;
    case (st_q)
      QS_IDLE: if (go) st_d = QS_LO;
      QS_LO:   if (beat_end) st_d = QS_HI;
      QS_HI:   if (beat_end) st_d = QS_DONE;
      default: st_d = QS_IDLE;
    endcase

    issued_d = issued_q;
    if (beat_end)              issued_d = 1'b0;
    else if (acc && !store_q)  issued_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= QS_IDLE;
      issued_q <= 1'b0;
      store_q  <= 1'b0;
      reg_q    <= '0;
    end else begin
      st_q     <= st_d;
      issued_q <= issued_d;
      if (go) begin
        store_q <= cmd_store;
        reg_q   <= cmd_reg;
      end
    end
  end

  // R4: write-back pulse lasts one cycle
  assert_wb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
  // R5: a skipped load leaves the port quiet and the sequencer idle
  assert_skip_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_store && cmd_reg == '0) |=> (cmd_ready && !mem_req));
  // R5: no write-back ever targets register 0
  assert_wb_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_reg != '0));
  // R8: a stalled request stays raised
  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> mem_req);
  // R7: an executed command makes the sequencer busy
  assert_busy_after_go_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !cmd_ready);
endmodule

// File: rtl/qls_data.sv
module qls_data #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [2*DW-1:0] sdata,
  input  logic          beat_hi,
  input  logic          cap_lo,
  input  logic          cap_hi,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] wdata,
  output logic [2*DW-1:0] result
);
  logic [2*DW-1:0] sbuf_q;
  logic [DW-1:0]   lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbuf_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (go)     sbuf_q <= sdata;
      if (cap_lo) lo_q   <= rdata;
      if (cap_hi) hi_q   <= rdata;
    end
  end

  always_comb begin
    wdata  = beat_hi ? sbuf_q[2*DW-1:DW] : sbuf_q[DW-1:0];
    result = {hi_q, lo_q};
  end
endmodule

// File: rtl/qls_seq.sv
module qls_seq #(
  parameter int AW     = 64,
  parameter int DW     = 64,
  parameter int OFS_W  = 16,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_store,
  input  logic [AW-1:0]     cmd_base,
  input  logic [OFS_W-1:0]  cmd_offset,
  input  logic [RIDX_W-1:0] cmd_reg,
  input  logic [2*DW-1:0]   cmd_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DW-1:0]     mem_rdata,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_reg,
  output logic [2*DW-1:0]   wb_data
);
  localparam int BEAT_BYTES = DW / 8;
  localparam int BEAT_B     = $clog2(BEAT_BYTES);
  localparam int ALIGN_B    = BEAT_B + 1;

  logic [AW-1:0] aligned, addr_q;
  logic go, beat_hi, cap_lo, cap_hi, is_store;

  qls_addr_gen #(.AW(AW), .OFS_W(OFS_W), .ALIGN_B(ALIGN_B)) u_addr (
    .base(cmd_base), .ofs(cmd_offset), .aligned(aligned));

  qls_ctrl #(.RIDX_W(RIDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
    .cmd_reg(cmd_reg), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
    .cmd_ready(cmd_ready), .go(go), .mem_req(mem_req), .is_store(is_store),
    .beat_hi(beat_hi), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .wb_valid(wb_valid), .wb_reg(wb_reg));

  qls_data #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n), .go(go), .sdata(cmd_wdata), .beat_hi(beat_hi),
    .cap_lo(cap_lo), .cap_hi(cap_hi), .rdata(mem_rdata),
    .wdata(mem_wdata), .result(wb_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (go) addr_q <= aligned;
  end

  always_comb begin
    mem_addr = beat_hi ? (addr_q + AW'(BEAT_BYTES)) : addr_q;
    mem_we   = is_store;
  end

  // R1: every beat address is doubleword aligned
  assert_beat_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[BEAT_B-1:0] == '0));
  // R3: the first request after an executed command is the lower half
  assert_lower_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_store || cmd_reg != '0)) |=>
      (mem_req && !mem_addr[BEAT_B]));
  // R8: a stalled beat keeps its address, direction and data
  assert_beat_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  // R9: stores never produce a write-back
  assert_store_no_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !wb_valid);
endmodule

// File: tb/tb_qls_seq.sv
module tb_qls_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         cmd_valid = 1'b0, cmd_store = 1'b0;
  logic         cmd_ready;
  logic [63:0]  cmd_base = '0;
  logic [15:0]  cmd_offset = '0;
  logic [4:0]   cmd_reg = '0;
  logic [127:0] cmd_wdata = '0;
  logic         mem_req, mem_we;
  logic [63:0]  mem_addr, mem_wdata;
  logic         mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [63:0]  mem_rdata = '0;
  logic         wb_valid;
  logic [4:0]   wb_reg;
  logic [127:0] wb_data;

  qls_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_store(cmd_store), .cmd_base(cmd_base), .cmd_offset(cmd_offset),
    .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .wb_valid(wb_valid),
    .wb_reg(wb_reg), .wb_data(wb_data));

  int checks = 0, errs = 0;
  int cyc = 0;
  logic [63:0] mem [64];
  logic [63:0] log_addr [4];
  logic        log_we [4];
  logic [63:0] log_wd [4];
  int n_log = 0;
  int wb_cnt = 0, wb_cyc = 0, last_rv_cyc = 0;
  logic [127:0] wb_seen = '0;
  logic [4:0]   wb_reg_seen = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] exp_ea(logic [63:0] b, logic [15:0] o);
    logic [63:0] s;
    s = b + {{48{o[15]}}, o};
    return {s[63:4], 4'h0};
  endfunction

  function automatic int idx(logic [63:0] a);
    return int'(a[8:3]);
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural memory with random back-pressure and read latency
  initial begin
    bit p_req = 0, p_rdy = 0, p_we = 0, rv_pend = 0;
    logic [63:0] p_addr = '0, p_wd = '0, rv_addr = '0;
    int rv_cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ready = 0; mem_rvalid = 0; p_req = 0; p_rdy = 0; rv_pend = 0;
        continue;
      end
      mem_rvalid = 0;
      if (p_req && !p_rdy) begin
        // R8: stalled request must persist unchanged
        chk(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wd,
            "R8 stalled beat changed", {mem_req, mem_addr}, {1'b1, p_addr});
      end
      if (rv_pend) begin
        if (rv_cnt == 0) begin
          mem_rvalid = 1; mem_rdata = mem[idx(rv_addr)];
          rv_pend = 0; last_rv_cyc = cyc;
        end else rv_cnt--;
      end
      if (p_req && p_rdy) begin
        if (n_log < 4) begin
          log_addr[n_log] = p_addr; log_we[n_log] = p_we; log_wd[n_log] = p_wd;
        end
        n_log++;
        if (p_we) mem[idx(p_addr)] = p_wd;
        else begin rv_pend = 1; rv_cnt = int'($urandom % 3); rv_addr = p_addr; end
      end
      mem_ready = ($urandom % 4) != 0;
      p_req = mem_req; p_rdy = mem_ready; p_addr = mem_addr;
      p_we = mem_we; p_wd = mem_wdata;
      if (wb_valid) begin
        wb_cnt++; wb_cyc = cyc; wb_seen = wb_data; wb_reg_seen = wb_reg;
      end
    end
  end

  task automatic run_op(bit st, logic [63:0] base, logic [15:0] ofs,
                        logic [4:0] r, logic [127:0] wd);
    logic [63:0] ea, e_lo, e_hi;
    int wb0;
    ea = exp_ea(base, ofs);
    e_lo = mem[idx(ea)];
    e_hi = mem[idx(ea + 64'd8)];
    wb0 = wb_cnt;
    chk(cmd_ready, "R7 ready before command", {127'b0, cmd_ready}, 128'd1);
    n_log = 0;
    cmd_valid = 1; cmd_store = st; cmd_base = base; cmd_offset = ofs;
    cmd_reg = r; cmd_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    if (!st && r == 0) begin
      chk(cmd_ready && !mem_req, "R5 skipped load not idle",
          {cmd_ready, mem_req}, 2'b10);
      repeat (3) @(negedge clk);
      chk(n_log == 0 && wb_cnt == wb0, "R5 skipped load touched port",
          128'(n_log), 128'd0);
    end else begin
      chk(!cmd_ready, "R7 ready while busy", {127'b0, cmd_ready}, 128'd0);
      while (!cmd_ready) @(negedge clk);
      chk(n_log == 2, "R2 beat count", 128'(n_log), 128'd2);
      chk(log_addr[0] == ea, "R1 first beat address", 128'(log_addr[0]), 128'(ea));
      chk(log_addr[1] == ea + 64'd8, "R2 second beat address",
          128'(log_addr[1]), 128'(ea + 64'd8));
      chk(log_we[0] == st && log_we[1] == st, "R2 beat direction",
          {log_we[0], log_we[1]}, {st, st});
      if (st) begin
        chk(log_wd[0] == wd[63:0] && log_wd[1] == wd[127:64],
            r == 0 ? "R6 R3 store halves (reg 0)" : "R3 store halves",
            {log_wd[1], log_wd[0]}, wd);
        chk(wb_cnt == wb0, "R9 store wrote back", 128'(wb_cnt - wb0), 128'd0);
      end else begin
        chk(wb_cnt == wb0 + 1, "R4 write-back count", 128'(wb_cnt - wb0), 128'd1);
        chk(wb_seen == {e_hi, e_lo}, "R4 load data", wb_seen, {e_hi, e_lo});
        chk(wb_reg_seen == r, "R4 load register", 128'(wb_reg_seen), 128'(r));
        chk(wb_cyc == last_rv_cyc + 1, "R4 write-back timing",
            128'(wb_cyc), 128'(last_rv_cyc + 1));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mem[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !mem_req && !wb_valid, "R10 reset state",
        {cmd_ready, mem_req, wb_valid}, 3'b100);

    // directed: unaligned base, positive offset
    run_op(1, 64'h0000_0000_0000_1007, 16'h0003, 5'd4,
           128'h1111_2222_3333_4444_5555_6666_7777_8888);
    run_op(0, 64'h0000_0000_0000_100F, 16'h0000, 5'd9, '0);
    // directed: negative offset
    run_op(1, 64'h0000_0000_0000_2005, 16'hFFF0, 5'd0,
           128'hAAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0123_4567);
    run_op(0, 64'h0000_0000_0000_1FF0, 16'h0004, 5'd31, '0);
    // directed: load to register 0 is skipped
    run_op(0, 64'h0000_0000_0000_1000, 16'h0010, 5'd0, '0);
    // back-to-back random mix
    for (int k = 0; k < 80; k++) begin
      bit st;
      logic [4:0] r;
      st = $urandom % 2;
      r = (($urandom % 6) == 0) ? 5'd0 : 5'($urandom);
      run_op(st, {$urandom, $urandom}, 16'($urandom), r,
             {$urandom, $urandom, $urandom, $urandom});
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule